// File: doc/BRIEF.md
# Per-Stream Serial Skew Aligner

This block sits between a bank of serial TDM lines and the switching core of a time-slot interchange. It runs from one fast clock at exactly four times the serial bit rate, so a quarter of a bit lasts one clock cycle. A single-cycle frame pulse marks the frame boundary. Every stream has its own receive-delay code and its own transmit-advance code.

On the receive side, each line is sampled late by a programmable number of quarter bits. This lets lines with different board skew be captured cleanly. The recovered bits are then put back onto one common bit grid derived from the frame pulse. All streams therefore reach the core aligned, whatever delay each one uses. A global mode input moves the sampling instant within the delayed bit.

On the transmit side, each outgoing stream can be moved earlier by zero to three fast-clock cycles, measured against a regenerated output frame pulse. Codes for both sides are copied into the working state only on a frame pulse, so a mid-frame change never produces a glitch.

Top module: `tdm_skew_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, `rx_bit`, `tx_ser` and `fp_out` are all 0.
- R2: A bit counter is cleared by each frame pulse edge F and advances every cycle modulo 4. `rx_bit` changes only on edges where the counter is 0, so each recovered bit is held for four cycles on a grid anchored to F. This grid is the same for every stream.
- R3: A stream's 5-bit receive-delay code d gives a delay of d quarter bits, from 0 to 7.75 bits. With `samp_early`=0, the `rx_bit` value loaded at edge F+4k+36 is the value `rx_ser` had at edge F+4k+d+2.
- R4: With `samp_early`=1, the sampling instant moves one quarter bit earlier. The value loaded at edge F+4k+36 is the `rx_ser` value from edge F+4k+d+1.
- R5: Stream s takes its delay code from bits [5s+4:5s] of `rx_dly_cfg` and its advance code from bits [2s+1:2s] of `tx_adv_cfg`. Each stream follows only its own codes.
- R6: A new receive-delay code is taken up on the frame pulse edge. Samples taken on that edge and before it use the previous code.
- R7: `fp_out` repeats `fp_in` four cycles later. With advance code 0, a value presented on `tx_bit` appears on `tx_ser` four cycles later, aligned to `fp_out`.
- R8: With advance code a (0..3), `tx_ser` repeats `tx_bit` after 4-a cycles. The stream therefore leads its normal alignment by a fast-clock cycles.
- R9: A new advance code is taken up only on a frame pulse edge.
- R10: The extreme delay code 31 works in both sampling modes with no loss of recovered bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four cycles per serial bit |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_in | input | 1 | Single-cycle frame boundary pulse |
| samp_early | input | 1 | Global sampling mode: 1 samples one quarter bit earlier |
| rx_ser | input | N_STREAMS | Incoming serial lines |
| rx_dly_cfg | input | N_STREAMS*DLY_W | Packed per-stream receive-delay codes |
| rx_bit | output | N_STREAMS | Delay-compensated bits on the common grid |
| tx_bit | input | N_STREAMS | Outgoing serial data from the core |
| tx_adv_cfg | input | N_STREAMS*ADV_W | Packed per-stream transmit-advance codes |
| tx_ser | output | N_STREAMS | Advanced outgoing serial lines |
| fp_out | output | 1 | Regenerated output frame pulse |

## Verification
If a tap index is wrong, or a delay code is captured at the wrong time, `rx_bit` takes a bit from the wrong quarter-bit position. Because the bench drives new random line values every cycle, the error shows up on the next grid edge, which comes within four cycles. A broken bit counter moves every stream's grid at once and shows up within one bit time. An advance pipeline or fp_out delay that is off by one corrupts `tx_ser` or `fp_out` on the very next cycle. Codes that are latched at the wrong time only differ from the model after a mid-frame reprogramming, and those cases are exercised on purpose.

// File: rtl/tdm_align_pkg.sv
// Package: shared constants for the skew aligner.
// Assumes the fast clock runs at four cycles per serial bit.
package tdm_align_pkg;
    localparam int QUARTERS_PER_BIT = 4;
    // Sampling offset, in quarter bits, inside a delayed bit.
    localparam int SAMPLE_OFS_NORMAL = 2;
    localparam int SAMPLE_OFS_EARLY  = 1;
    typedef logic [1:0] quarter_t;
endpackage

// File: rtl/tdm_bit_phase.sv
// Module: quarter-bit phase counter that is cleared by the frame pulse.
// Gives out a strobe on the first quarter of every bit slot.
// Assumes fp_in lasts exactly one cycle.
module tdm_bit_phase
    import tdm_align_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fp_in,
    output logic bit_strobe
);
    quarter_t phase_q;

    // Advance the quarter counter; the pulse cycle counts as quarter 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase_q <= '0;
        else if (fp_in) phase_q <= quarter_t'(1);
        else            phase_q <= phase_q + quarter_t'(1);
    end

    // Strobe at quarter 0 of each bit slot.
    always_comb bit_strobe = fp_in || (phase_q == '0);

    // R2
    no_double_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !fp_in) |=> (!bit_strobe || fp_in));
endmodule

// File: rtl/tdm_rx_delay.sv
// Module: receive aligner for one stream. It keeps a history of the line
// and picks the tap that undoes the programmed delay, so that the output
// lands on the common bit grid with a fixed latency.
// Assumes bit_strobe comes from tdm_bit_phase.
module tdm_rx_delay
    import tdm_align_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_in,
    input  logic             bit_strobe,
    input  logic             samp_early,
    input  logic             line_in,
    input  logic [DLY_W-1:0] dly_code,
    output logic             bit_out
);
    localparam int HIST  = (1 << DLY_W) + QUARTERS_PER_BIT;
    localparam int TAP_W = $clog2(HIST);

    logic [HIST-1:0]  hist_q;
    logic [DLY_W-1:0] dly_act_q;
    logic [TAP_W-1:0] tap;

    // Shift the line into the history register every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST-2:0], line_in};
    end

    // Take up a new delay code only on the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     dly_act_q <= '0;
        else if (fp_in) dly_act_q <= dly_code;
    end

    // Tap that reaches back to the chosen quarter of the delayed bit.
    always_comb tap = TAP_W'(HIST - 1 - int'(dly_act_q)
                      - (samp_early ? SAMPLE_OFS_EARLY : SAMPLE_OFS_NORMAL));

    // Load the recovered bit on the grid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          bit_out <= 1'b0;
        else if (bit_strobe) bit_out <= hist_q[tap];
    end

    // R2
    rx_grid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_strobe |=> $stable(bit_out));
    // R6
    rx_code_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_in |=> $stable(dly_act_q));
endmodule

// File: rtl/tdm_tx_advance.sv
// Module: transmit advance for one stream. The normal path is a fixed
// pipeline; advancing by a cycles takes a tap a stages shorter.
// Assumes the advance code changes take effect on the frame pulse only.
module tdm_tx_advance #(
    parameter int ADV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_in,
    input  logic             data_in,
    input  logic [ADV_W-1:0] adv_code,
    output logic             ser_out
);
    localparam int ADV_MAX = (1 << ADV_W) - 1;

    logic [ADV_MAX-1:0] pipe_q;
    logic [ADV_MAX:0]   window;
    logic [ADV_W-1:0]   adv_act_q;

    // Pipeline of the outgoing data.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[ADV_MAX-2:0], data_in};
    end

    // Take up a new advance code on the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     adv_act_q <= '0;
        else if (fp_in) adv_act_q <= adv_code;
    end

    // Candidate taps: index 0 is the current input.
    always_comb window = {pipe_q, data_in};

    // Register the selected tap as the line output.
    always_ff @(posedge clk) begin
        if (!rst_n) ser_out <= 1'b0;
        else        ser_out <= window[ADV_MAX - int'(adv_act_q)];
    end

    // R9
    tx_code_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_in |=> $stable(adv_act_q));
endmodule

// File: rtl/tdm_skew_aligner.sv
// Module: top of the per-stream skew aligner. One shared bit-phase
// generator, one receive aligner and one transmit advancer per stream,
// and a regenerated output frame pulse on the normal transmit latency.
// Assumes a fast clock at four times the bit rate.
module tdm_skew_aligner #(
    parameter int N_STREAMS = 16,
    parameter int DLY_W     = 5,
    parameter int ADV_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fp_in,
    input  logic                       samp_early,
    input  logic [N_STREAMS-1:0]       rx_ser,
    input  logic [N_STREAMS*DLY_W-1:0] rx_dly_cfg,
    output logic [N_STREAMS-1:0]       rx_bit,
    input  logic [N_STREAMS-1:0]       tx_bit,
    input  logic [N_STREAMS*ADV_W-1:0] tx_adv_cfg,
    output logic [N_STREAMS-1:0]       tx_ser,
    output logic                       fp_out
);
    localparam int ADV_MAX = (1 << ADV_W) - 1;

    logic              bit_strobe;
    logic [ADV_MAX:0]  fp_pipe_q;

    tdm_bit_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_in      (fp_in),
        .bit_strobe (bit_strobe)
    );

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
        tdm_rx_delay #(.DLY_W(DLY_W)) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .fp_in      (fp_in),
            .bit_strobe (bit_strobe),
            .samp_early (samp_early),
            .line_in    (rx_ser[s]),
            .dly_code   (rx_dly_cfg[s*DLY_W +: DLY_W]),
            .bit_out    (rx_bit[s])
        );
        tdm_tx_advance #(.ADV_W(ADV_W)) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .fp_in    (fp_in),
            .data_in  (tx_bit[s]),
            .adv_code (tx_adv_cfg[s*ADV_W +: ADV_W]),
            .ser_out  (tx_ser[s])
        );
    end

    // Delay the frame pulse to match the unadvanced transmit latency.
    always_ff @(posedge clk) begin
        if (!rst_n) fp_pipe_q <= '0;
        else        fp_pipe_q <= {fp_pipe_q[ADV_MAX-1:0], fp_in};
    end

    always_comb fp_out = fp_pipe_q[ADV_MAX];

    // R7
    fp_out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp_in |-> ##4 fp_out);
endmodule

// File: tb/tdm_skew_aligner_bench.sv
module tdm_skew_aligner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int DW = 5;
    localparam int AW = 2;
    localparam int FRAME_CYC = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fp_in = 1'b0;
    logic samp_early = 1'b0;
    logic [N-1:0] rx_ser = '0;
    logic [N-1:0] tx_bit = '0;
    logic [N*DW-1:0] rx_dly_cfg = '0;
    logic [N*AW-1:0] tx_adv_cfg = '0;
    logic [N-1:0] rx_bit;
    logic [N-1:0] tx_ser;
    logic fp_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_skew_aligner u_tdm_skew_aligner (
        .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .samp_early(samp_early),
        .rx_ser(rx_ser), .rx_dly_cfg(rx_dly_cfg), .rx_bit(rx_bit),
        .tx_bit(tx_bit), .tx_adv_cfg(tx_adv_cfg), .tx_ser(tx_ser),
        .fp_out(fp_out)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int fcnt = 10;
    string rx_tag = "R2";
    string tx_tag = "R7";

    // Reference state: line history (index j = value from j+1 edges ago).
    int  cnt_m;
    int  d_m [N];
    int  a_m [N];
    bit  ih  [N][40];
    bit  th  [N][4];
    bit  fh  [4];
    bit  rx_e [N];
    bit  tx_e [N];
    bit  fpo_e;

    task automatic chk(string tag, int act, int exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        cnt_m = 0;
        fpo_e = 0;
        for (int s = 0; s < N; s++) begin
            d_m[s] = 0; a_m[s] = 0; rx_e[s] = 0; tx_e[s] = 0;
            for (int j = 0; j < 40; j++) ih[s][j] = 0;
            for (int j = 0; j < 4; j++) th[s][j] = 0;
        end
        for (int j = 0; j < 4; j++) fh[j] = 0;
    endtask

    // Effect of the coming clock edge, from the inputs now applied.
    task automatic model_step();
        bit grid;
        grid = fp_in || (cnt_m == 0);
        for (int s = 0; s < N; s++) begin
            if (grid) rx_e[s] = ih[s][35 - d_m[s] - (samp_early ? 1 : 2)];
            tx_e[s] = (a_m[s] == 3) ? tx_bit[s] : th[s][2 - a_m[s]];
            for (int j = 39; j > 0; j--) ih[s][j] = ih[s][j-1];
            ih[s][0] = rx_ser[s];
            for (int j = 3; j > 0; j--) th[s][j] = th[s][j-1];
            th[s][0] = tx_bit[s];
            if (fp_in) begin
                d_m[s] = int'(rx_dly_cfg[s*DW +: DW]);
                a_m[s] = int'(tx_adv_cfg[s*AW +: AW]);
            end
        end
        fpo_e = fh[2];
        for (int j = 3; j > 0; j--) fh[j] = fh[j-1];
        fh[0] = fp_in;
        cnt_m = fp_in ? 1 : (cnt_m + 1) % 4;
    endtask

    task automatic one_cycle();
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
            chk(rx_tag, int'(rx_bit[s]), int'(rx_e[s]), $sformatf("rx_bit[%0d]", s));
            chk(tx_tag, int'(tx_ser[s]), int'(tx_e[s]), $sformatf("tx_ser[%0d]", s));
        end
        chk(tx_tag, int'(fp_out), int'(fpo_e), "fp_out");
        rst_n  = 1'b1;
        rx_ser = N'($urandom());
        tx_bit = N'($urandom());
        fp_in  = (fcnt == 0);
        fcnt   = (fcnt + 1) % FRAME_CYC;
        model_step();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) one_cycle();
    endtask

    task automatic set_all(int d, int a);
        for (int s = 0; s < N; s++) begin
            rx_dly_cfg[s*DW +: DW] = DW'(d);
            tx_adv_cfg[s*AW +: AW] = AW'(a);
        end
    endtask

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1", int'(rx_bit), 0, "rx_bit in reset");
        chk("R1", int'(tx_ser), 0, "tx_ser in reset");
        chk("R1", int'(fp_out), 0, "fp_out in reset");
        rx_tag = "R1"; tx_tag = "R1";
        run(1);
        rx_tag = "R2"; tx_tag = "R7";
        run(3 * FRAME_CYC);
        // R3: uniform delay code
        set_all(7, 0);
        rx_tag = "R3";
        run(3 * FRAME_CYC);
        // R5 and R8: per-stream codes and advances
        for (int s = 0; s < N; s++) begin
            rx_dly_cfg[s*DW +: DW] = DW'((s * 5 + 3) % 32);
            tx_adv_cfg[s*AW +: AW] = AW'(s % 4);
        end
        rx_tag = "R5"; tx_tag = "R8";
        run(3 * FRAME_CYC);
        // R10: maximum delay code, both sampling modes
        set_all(31, 3);
        rx_tag = "R10";
        run(2 * FRAME_CYC);
        samp_early = 1'b1;
        run(2 * FRAME_CYC);
        // R4: early sampling with mixed codes
        for (int s = 0; s < N; s++) rx_dly_cfg[s*DW +: DW] = DW'(s * 2);
        rx_tag = "R4";
        run(2 * FRAME_CYC);
        // R6 and R9: reprogram in the middle of a frame
        samp_early = 1'b0;
        rx_tag = "R6"; tx_tag = "R9";
        while (fcnt != 60) run(1);
        for (int s = 0; s < N; s++) begin
            rx_dly_cfg[s*DW +: DW] = DW'(31 - s);
            tx_adv_cfg[s*AW +: AW] = AW'(3 - (s % 4));
        end
        run(FRAME_CYC + 20);
        set_all(12, 1);
        run(2 * FRAME_CYC);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule